// File: doc/BRIEF.md
# Interrupt Flag and Enable Registers

This block holds the pending-event flags and the per-event enable mask of a 6522-style peripheral, and drives the peripheral's single interrupt request. Timer and shift-register logic elsewhere in the peripheral raise flags with one-cycle event pulses. A byte-wide bus decoder writes the two registers and sends clear pulses when the host reads registers that have a read side effect.

The flag register clears on write-one. The enable register is written in set or clear mode, and bit 7 of the written byte picks the mode. When either register is read, bit 7 carries a marker instead of stored state. For the flag register that bit is a computed "something enabled is pending" summary. For the enable register it is a constant one. The request output is registered. It rises only for the enabled timer events and the enabled shift-done event.

Top module: `irq_ctl`

## Requirements
- R1: After reset, the flag read value is 0x00, the enable read value is 0x80 and `irq` is low.
- R2: An event pulse sets its flag bit, and the bit reads as one from the cycle after the pulse. The bits are: bit 6 timer 1, bit 5 timer 2, bit 4 shift clock, bit 3 shift data, bit 2 shift done. Bits 1 and 0 always read zero.
- R3: A flag-register write clears every flag whose written data bit is one. Flags whose written bit is zero keep their value.
- R4: When an event pulse and any clear of the same flag arrive in the same cycle, the flag ends up set.
- R5: A shift-register read pulse clears flags 2, 3 and 4. A timer-1 low-byte read pulse clears flag 6. A timer-2 low-byte read pulse clears flag 5. No other flag changes.
- R6: An enable write with data bit 7 at one ORs data bits 6..0 into the enable register.
- R7: An enable write with data bit 7 at zero clears each enable bit whose data bit is one. All other enable bits keep their value.
- R8: Bit 7 of the enable read value is always one. Bits 6..0 are the stored enables.
- R9: Bits 6..0 of the flag read value are the flags. Bit 7 is one exactly when some flag in bits 6..0 is set together with its enable.
- R10: `irq` is a register. One cycle after the flags and enables share a set bit among bits 2, 5 and 6, `irq` is high, and it is low otherwise. A shared set bit at 3 or 4 alone does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_flag | input | 1 | Write strobe for the flag register (write-one-to-clear) |
| wr_enable | input | 1 | Write strobe for the enable register (set/clear by bit 7) |
| wr_data | input | 8 | Write data byte |
| rd_shift | input | 1 | Shift-register read side-effect pulse |
| rd_t1_lo | input | 1 | Timer-1 low counter byte read side-effect pulse |
| rd_t2_lo | input | 1 | Timer-2 low counter byte read side-effect pulse |
| t1_fire | input | 1 | Timer-1 event pulse |
| t2_fire | input | 1 | Timer-2 event pulse |
| sr_done | input | 1 | Shift-register done event pulse |
| sr_data_evt | input | 1 | Shift data event pulse |
| sr_clk_evt | input | 1 | Shift clock event pulse |
| flag_rd | output | 8 | Flag read value, with the summary in bit 7 |
| enable_rd | output | 8 | Enable read value, with bit 7 fixed at one |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default request mask of 0x64, so only flag bits 2, 5 and 6 can raise the request. With this mask, enabling the shift data or shift clock flag sets the read summary bit while `irq` stays low. A directed case checks that split, and random traffic also reaches it. The random stimulus often places event pulses in the same cycle as write-one clears and read-side clears, which exercises the rule that the set wins.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int FLAG_W  = 7;
  localparam int BUS_W   = FLAG_W + 1;
  localparam int MARK_B  = FLAG_W;
  localparam int B_SDONE = 2;
  localparam int B_SDATA = 3;
  localparam int B_SCLK  = 4;
  localparam int B_T2    = 5;
  localparam int B_T1    = 6;

  typedef logic [FLAG_W-1:0] flag_vec_t;

  // next flag state: clears applied first, then sets, so a set wins
  function automatic flag_vec_t flag_update(flag_vec_t cur, flag_vec_t set_v, flag_vec_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // set/clear write selected by the marker bit
  function automatic flag_vec_t enable_update(flag_vec_t cur, logic [BUS_W-1:0] d);
    return d[MARK_B] ? (cur | d[FLAG_W-1:0]) : (cur & ~d[FLAG_W-1:0]);
  endfunction

  function automatic logic any_shared(flag_vec_t f, flag_vec_t e, flag_vec_t m);
    return |(f & e & m);
  endfunction
endpackage

// File: rtl/irq_clear_decode.sv
module irq_clear_decode
  import irq_ctl_pkg::*;
(
  input  logic             wr_flag,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_shift,
  input  logic             rd_t1_lo,
  input  logic             rd_t2_lo,
  output flag_vec_t        clr_vec
);
  flag_vec_t rd_clr;

  always_comb begin
    rd_clr = '0;
    rd_clr[B_SDONE] = rd_shift;
    rd_clr[B_SDATA] = rd_shift;
    rd_clr[B_SCLK]  = rd_shift;
    rd_clr[B_T1]    = rd_t1_lo;
    rd_clr[B_T2]    = rd_t2_lo;
    clr_vec = rd_clr | (wr_flag ? wr_data[FLAG_W-1:0] : '0);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  output flag_vec_t flag_q
);
  flag_vec_t flag_nxt;
  assign flag_nxt = flag_update(flag_q, set_vec, clr_vec);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_nxt[i];
    end

    // R4 / R2: a set pulse always leaves the flag set
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i]);
    // R3 / R5: a clear without a set leaves the flag clear
    a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);
    // R2: a flag without set or clear holds its value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flag_q[i]));
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_enable,
  input  logic [BUS_W-1:0] wr_data,
  output flag_vec_t        en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_enable) en_q <= enable_update(en_q, wr_data);
  end

  a_r6_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && wr_data[MARK_B]) |=>
      ((en_q & $past(wr_data[FLAG_W-1:0])) == $past(wr_data[FLAG_W-1:0])));
  a_r7_clear_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && !wr_data[MARK_B]) |=> ((en_q & $past(wr_data[FLAG_W-1:0])) == '0));
  a_r7_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(en_q));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_ctl_pkg::*;
#(
  parameter flag_vec_t REQ_MASK = 7'h64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  flag_vec_t        flag_q,
  input  flag_vec_t        en_q,
  output logic [BUS_W-1:0] flag_rd,
  output logic [BUS_W-1:0] enable_rd,
  output logic             irq
);
  logic pend_any;
  logic pend_req;

  assign pend_any  = any_shared(flag_q, en_q, '1);
  assign pend_req  = any_shared(flag_q, en_q, REQ_MASK);
  assign flag_rd   = {pend_any, flag_q};
  assign enable_rd = {1'b1, en_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pend_req;
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter logic [6:0] REQ_MASK = 7'h64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_flag,
  input  logic       wr_enable,
  input  logic [7:0] wr_data,
  input  logic       rd_shift,
  input  logic       rd_t1_lo,
  input  logic       rd_t2_lo,
  input  logic       t1_fire,
  input  logic       t2_fire,
  input  logic       sr_done,
  input  logic       sr_data_evt,
  input  logic       sr_clk_evt,
  output logic [7:0] flag_rd,
  output logic [7:0] enable_rd,
  output logic       irq
);
  flag_vec_t set_vec;
  flag_vec_t clr_vec;
  flag_vec_t flag_q;
  flag_vec_t en_q;

  always_comb begin
    set_vec = '0;
    set_vec[B_T1]    = t1_fire;
    set_vec[B_T2]    = t2_fire;
    set_vec[B_SCLK]  = sr_clk_evt;
    set_vec[B_SDATA] = sr_data_evt;
    set_vec[B_SDONE] = sr_done;
  end

  irq_clear_decode u_clr (
    .wr_flag(wr_flag), .wr_data(wr_data), .rd_shift(rd_shift),
    .rd_t1_lo(rd_t1_lo), .rd_t2_lo(rd_t2_lo), .clr_vec(clr_vec)
  );

  irq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flag_q(flag_q)
  );

  irq_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .wr_enable(wr_enable), .wr_data(wr_data), .en_q(en_q)
  );

  irq_summary #(.REQ_MASK(REQ_MASK)) u_sum (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .en_q(en_q),
    .flag_rd(flag_rd), .enable_rd(enable_rd), .irq(irq)
  );

  // R10: request follows the visible masked state by one cycle
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_rd[6:0] & enable_rd[6:0] & REQ_MASK)) |=> irq);
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_rd[6:0] & enable_rd[6:0] & REQ_MASK)) |=> !irq);
  // R8: enable marker bit
  a_r8_marker: assert property (@(posedge clk) disable iff (!rst_n) enable_rd[7]);
  // R9: summary tracks enabled flags
  a_r9_summary: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd[7] == (|(flag_rd[6:0] & enable_rd[6:0])));
  // R2: flag bits without a source stay clear
  a_r2_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd[1:0] == 2'b00);
endmodule

// File: tb/test_irq_ctl.sv
module test_irq_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_flag = 0, wr_enable = 0, rd_shift = 0, rd_t1_lo = 0, rd_t2_lo = 0;
  logic t1_fire = 0, t2_fire = 0, sr_done = 0, sr_data_evt = 0, sr_clk_evt = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] flag_rd, enable_rd;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [6:0] mf = '0, me = '0;
  logic m_irq = 1'b0;
  localparam logic [6:0] MASK = 7'b1100100;

  always #5 clk = ~clk;

  irq_ctl i_irq_ctl (
    .clk(clk), .rst_n(rst_n), .wr_flag(wr_flag), .wr_enable(wr_enable), .wr_data(wr_data),
    .rd_shift(rd_shift), .rd_t1_lo(rd_t1_lo), .rd_t2_lo(rd_t2_lo),
    .t1_fire(t1_fire), .t2_fire(t2_fire), .sr_done(sr_done),
    .sr_data_evt(sr_data_evt), .sr_clk_evt(sr_clk_evt),
    .flag_rd(flag_rd), .enable_rd(enable_rd), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ev_bits();
    logic [6:0] s = '0;
    s[6] = t1_fire; s[5] = t2_fire; s[4] = sr_clk_evt; s[3] = sr_data_evt; s[2] = sr_done;
    return s;
  endfunction

  function automatic logic [6:0] clr_bits();
    logic [6:0] c = '0;
    if (rd_shift) c = c | 7'b0011100;
    if (rd_t1_lo) c[6] = 1'b1;
    if (rd_t2_lo) c[5] = 1'b1;
    if (wr_flag) c = c | wr_data[6:0];
    return c;
  endfunction

  // advance one clock and update the model from the inputs held across it
  task automatic step(string tag);
    @(posedge clk);
    #1;
    m_irq = |(mf & me & MASK);
    mf = (mf & ~clr_bits()) | ev_bits();
    if (wr_enable) me = wr_data[7] ? (me | wr_data[6:0]) : (me & ~wr_data[6:0]);
    @(negedge clk);
    chk({tag, " R2/R3/R5 flags"}, {1'b0, flag_rd[6:0]}, {1'b0, mf});
    chk({tag, " R9 summary"}, {7'b0, flag_rd[7]}, {7'b0, |(mf & me)});
    chk({tag, " R6/R7/R8 enable"}, enable_rd, {1'b1, me});
    chk({tag, " R10 irq"}, {7'b0, irq}, {7'b0, m_irq});
  endtask

  task automatic idle();
    {wr_flag, wr_enable, rd_shift, rd_t1_lo, rd_t2_lo} = '0;
    {t1_fire, t2_fire, sr_done, sr_data_evt, sr_clk_evt} = '0;
    wr_data = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 flag", flag_rd, 8'h00);
    chk("R1 enable", enable_rd, 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R6 set enables 3 and 4 only; R2 shift data event
    wr_enable = 1; wr_data = 8'h98; step("R6 en34");
    idle(); sr_data_evt = 1; step("R2 sdata");
    idle(); step("R10 no irq for bit3");
    chk("R10 bit3 alone", {7'b0, irq}, 8'h00);
    chk("R9 summary bit3", flag_rd, 8'h88);

    // R4 set beats write-one clear and read clear
    idle(); t1_fire = 1; wr_flag = 1; wr_data = 8'h40; step("R4 wr");
    chk("R4 t1 kept", {7'b0, flag_rd[6]}, 8'h01);
    idle(); t1_fire = 1; rd_t1_lo = 1; step("R4 rd");
    chk("R4 t1 kept rd", {7'b0, flag_rd[6]}, 8'h01);

    // R10 enable t1: irq one cycle after enable change
    idle(); wr_enable = 1; wr_data = 8'hC0; step("R6 en6");
    chk("R10 irq lag", {7'b0, irq}, 8'h00);
    idle(); step("R10 irq up");
    chk("R10 irq high", {7'b0, irq}, 8'h01);

    // R5 read clears; R7 clear enables
    idle(); rd_shift = 1; step("R5 shift rd");
    idle(); rd_t1_lo = 1; step("R5 t1 rd");
    idle(); wr_enable = 1; wr_data = 8'h7F; step("R7 clr all");
    chk("R7 cleared", enable_rd, 8'h80);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      t1_fire = ($urandom % 4) == 0;
      t2_fire = ($urandom % 4) == 0;
      sr_done = ($urandom % 5) == 0;
      sr_data_evt = ($urandom % 6) == 0;
      sr_clk_evt = ($urandom % 6) == 0;
      rd_shift = ($urandom % 7) == 0;
      rd_t1_lo = ($urandom % 7) == 0;
      rd_t2_lo = ($urandom % 7) == 0;
      wr_data = 8'($urandom);
      case ($urandom % 4)
        0: wr_flag = 1;
        1: wr_enable = 1;
        default: ;
      endcase
      step("rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule